// File: doc/BRIEF.md
# Bus-programmed watchdog timer

This block is a watchdog timer that sits on a simple word-wide register bus. Software writes a 16-bit timeout, in ticks, into a count register. It then starts the timer through a control register. To keep the system alive, software must re-arm the countdown with a reload strobe before the counter runs out.

A synchronous prescaler turns the system clock into ticks. The tick length is selected at an input pin. If the counter reaches zero while the timer is running, the block does four things:

- it latches a sticky expiry flag;
- it issues a one-cycle request on either the reset output or the shutdown output, as the control register selects;
- it halts the countdown;
- it clears the run bit.

An external strap can disable the block entirely. While the strap is high, the timer cannot run and never raises a request. The control register reports the strap's level to software, which must treat the watchdog as unusable when that bit reads 1.

Top module: `wdt_timer`

## Requirements
- R1: Byte offset 0 (address bit 2 = 0) is the control register and offset 4 (bit 2 = 1) is the count register; address bits 1:0 are ignored. Control reads {0, bit3 strap, bit2 action, bit1 fired, bit0 run}; bits 31:4 read 0. Count reads the 16-bit timeout in bits 15:0 with 0 above. After reset control reads 0 and count reads 0xFFFF.
- R2: A count write stores data bits 15:0 and discards the upper bits. The stored value reaches the counter only on a reload, so writing it during a countdown does not change that countdown.
- R3: Writing control bit 0 = 1 starts the countdown from the counter's present value, and writing 0 stops it with the value held. A later start resumes from the held value.
- R4: Writing control bit 7 = 1 loads the counter from the count register and restarts the tick phase. Bit 7 always reads 0, and periodic reloads prevent expiry.
- R5: One tick lasts P = max(1, CLKS_PER_TICK >> res_sel_i) clock cycles. The running counter decrements once per tick.
- R6: Suppose a control write with bits 7 and 0 set is taken at clock edge E, with count N loaded. The expiry request is then high for exactly the one cycle after edge E+N*P+1, and run reads 0 afterwards. N = 0 expires right after edge E+1.
- R7: With control bit 2 = 0, expiry pulses reset_req_o and shutdown_req_o stays low. With bit 2 = 1, it pulses shutdown_req_o and reset_req_o stays low.
- R8: Fired (control bit 1) becomes 1 on expiry and stays 1 until software writes 1 to bit 1. Writing 0 to bit 1 has no effect.
- R9: While disable_strap_i is 1:
  - bit 3 reads 1;
  - run cannot be set, and a running timer stops;
  - no request is issued.

  Writes to bit 3 are ignored.
- R10: The largest timeout, 0xFFFF, gives 65535 ticks before expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access valid this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Byte offset within the register window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| res_sel_i | input | 2 | Tick resolution select |
| disable_strap_i | input | 1 | Hardware disable strap |
| reset_req_o | output | 1 | One-cycle system reset request |
| shutdown_req_o | output | 1 | One-cycle shutdown request |

## Verification
The countdown is run with several timeouts and tick resolutions: zero, small counts, and the full 0xFFFF at the shortest tick. The cycle of the request is measured from the arming write, which separates an off-by-one in the tick phase from one in the counter.

Further cases each target a distinct failure:
- Periodic reloads, and a count write that falls between reloads, expose a counter that follows the count register directly instead of latching on reload.
- A stop followed by a restart checks that the held value is resumed rather than reloaded.
- Strap assertion, both before starting and during a countdown, confirms that requests are blocked.
- A behavioural model checks both request pins and the read data on every clock.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned TIMEOUT_W = 16;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned ADDR_W    = 3;
  // control bit positions
  localparam int unsigned CB_RUN    = 0;
  localparam int unsigned CB_FIRED  = 1;
  localparam int unsigned CB_ACTION = 2;
  localparam int unsigned CB_STRAP  = 3;
  localparam int unsigned CB_RELOAD = 7;
  // address bit that selects the count register
  localparam int unsigned SEL_BIT   = 2;

  typedef struct packed {
    logic strap;
    logic action;
    logic fired;
    logic run;
  } ctrl_view_t;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned CLKS_PER_TICK = 125_000_000,
  parameter int unsigned SEL_W         = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clear_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int unsigned CNT_W = $clog2(CLKS_PER_TICK + 1);

  logic [CNT_W-1:0] cnt_q, per_raw, period;

  always_comb begin
    per_raw = CNT_W'(CLKS_PER_TICK) >> sel_i;
    period  = (per_raw == '0) ? CNT_W'(1) : per_raw;
    // >= keeps the tick alive if the resolution shrinks mid-period
    tick_o  = en_i && (cnt_q >= period - CNT_W'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (!en_i || clear_i || tick_o) cnt_q <= '0;
    else                                  cnt_q <= cnt_q + CNT_W'(1);
  end

  assert_idle_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt_q == '0);
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_val_i,
  input  logic             tick_i,
  output logic             zero_o
);
  logic [WIDTH-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '1;
    else if (load_i)                  cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0)   cnt_q <= cnt_q - WIDTH'(1);
  end

  assign zero_o = (cnt_q == '0);

  assert_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) - WIDTH'(1)));
  assert_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(load_val_i));
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
#(
  parameter int unsigned CLKS_PER_TICK = 125_000_000,
  parameter int unsigned RES_SEL_W     = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  input  logic [RES_SEL_W-1:0] res_sel_i,
  input  logic                 disable_strap_i,
  output logic                 reset_req_o,
  output logic                 shutdown_req_o
);
  localparam int unsigned VIEW_W = $bits(ctrl_view_t);

  logic                 ctrl_wr, cnt_wr, reload, expire, tick, zero;
  logic                 run_q, fired_q, action_q, rst_pulse_q, sd_pulse_q;
  logic [TIMEOUT_W-1:0] count_q;
  ctrl_view_t           view;

  assign ctrl_wr = req_i && we_i && !addr_i[SEL_BIT];
  assign cnt_wr  = req_i && we_i &&  addr_i[SEL_BIT];
  assign reload  = ctrl_wr && wdata_i[CB_RELOAD];
  // a control write in the same cycle takes precedence over expiry
  assign expire  = run_q && zero && !disable_strap_i && !ctrl_wr;

  wdt_prescaler #(.CLKS_PER_TICK(CLKS_PER_TICK), .SEL_W(RES_SEL_W)) u_presc (
    .clk_i, .rst_ni, .en_i(run_q), .clear_i(reload), .sel_i(res_sel_i), .tick_o(tick)
  );

  wdt_countdown #(.WIDTH(TIMEOUT_W)) u_cnt (
    .clk_i, .rst_ni, .load_i(reload), .load_val_i(count_q), .tick_i(tick), .zero_o(zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q       <= 1'b0;
      fired_q     <= 1'b0;
      action_q    <= 1'b0;
      count_q     <= '1;
      rst_pulse_q <= 1'b0;
      sd_pulse_q  <= 1'b0;
    end else begin
      if (disable_strap_i) run_q <= 1'b0;
      else if (ctrl_wr)    run_q <= wdata_i[CB_RUN];
      else if (expire)     run_q <= 1'b0;

      if (expire)                              fired_q <= 1'b1;
      else if (ctrl_wr && wdata_i[CB_FIRED])   fired_q <= 1'b0;

      if (ctrl_wr) action_q <= wdata_i[CB_ACTION];
      if (cnt_wr)  count_q  <= wdata_i[TIMEOUT_W-1:0];

      rst_pulse_q <= expire && !action_q;
      sd_pulse_q  <= expire &&  action_q;
    end
  end

  always_comb begin
    view = '{strap: disable_strap_i, action: action_q, fired: fired_q, run: run_q};
    if (addr_i[SEL_BIT]) rdata_o = DATA_W'(count_q);
    else                 rdata_o = DATA_W'(view[VIEW_W-1:0]);
  end

  assign reset_req_o    = rst_pulse_q;
  assign shutdown_req_o = sd_pulse_q;

  assert_single_cycle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reset_req_o || shutdown_req_o) |=> !reset_req_o && !shutdown_req_o);
  assert_halt_after_fire_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reset_req_o || shutdown_req_o) |-> !run_q && fired_q);
  assert_fired_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fired_q && !(ctrl_wr && wdata_i[CB_FIRED]) |=> fired_q);
  assert_strap_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disable_strap_i |=> !reset_req_o && !shutdown_req_o && !run_q);
  assert_action_route_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_req_o |-> $past(action_q));
endmodule

// File: tb/wdt_timer_bench.sv
module wdt_timer_bench;
  localparam int CPT = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [1:0]  res_sel_i = '0;
  logic        disable_strap_i = 1'b0;
  logic        reset_req_o, shutdown_req_o;

  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  wdt_timer #(.CLKS_PER_TICK(CPT)) u_wdt_timer (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .res_sel_i, .disable_strap_i, .reset_req_o, .shutdown_req_o
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int  m_run, m_fired, m_action, m_count, m_cnt, m_presc, m_prst, m_psd;
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_run = 0; m_fired = 0; m_action = 0; m_count = 65535; m_cnt = 65535;
      m_presc = 0; m_prst = 0; m_psd = 0;
    end else begin
      int per, tick, wr_c, wr_n, ld, exp_now;
      per = CPT >> res_sel_i; if (per == 0) per = 1;
      tick = m_run && (m_presc >= per - 1);
      wr_c = req_i && we_i && !addr_i[2];
      wr_n = req_i && we_i && addr_i[2];
      ld = wr_c && wdata_i[7];
      exp_now = m_run && (m_cnt == 0) && !disable_strap_i && !wr_c;
      m_prst = exp_now && !m_action;
      m_psd  = exp_now && m_action;
      if (!m_run || ld || tick) m_presc = 0; else m_presc++;
      if (ld) m_cnt = m_count; else if (tick && m_cnt != 0) m_cnt--;
      if (exp_now) m_fired = 1; else if (wr_c && wdata_i[1]) m_fired = 0;
      if (disable_strap_i) m_run = 0; else if (wr_c) m_run = wdata_i[0]; else if (exp_now) m_run = 0;
      if (wr_c) m_action = wdata_i[2];
      if (wr_n) m_count = wdata_i[15:0];
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk("R6 reset pulse vs model", 32'(reset_req_o), 32'(m_prst));
      chk("R7 shutdown pulse vs model", 32'(shutdown_req_o), 32'(m_psd));
      if (addr_i[2]) chk("R1 count read vs model", rdata_o, 32'(m_count));
      else chk("R1 ctrl read vs model", rdata_o,
               32'({disable_strap_i, m_action[0], m_fired[0], m_run[0]}));
    end
  end

  task automatic bus_wr(logic [2:0] a, logic [31:0] d);
    req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 0; we_i = 0; wdata_i = '0;
  endtask

  task automatic bus_rd(logic [2:0] a, output logic [31:0] d);
    req_i = 1; we_i = 0; addr_i = a;
    #1 d = rdata_o;
    @(negedge clk_i);
    req_i = 0;
  endtask

  task automatic wait_pulse(int k0, int limit, output int k, output bit sd);
    k = k0; sd = 0;
    while (!(reset_req_o || shutdown_req_o) && k < limit) begin
      @(negedge clk_i); k++;
    end
    if (!(reset_req_o || shutdown_req_o)) k = -1;
    else sd = shutdown_req_o;
  endtask

  initial begin
    logic [31:0] rd;
    int k; bit sd;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk("R1 reset outputs", {30'b0, reset_req_o, shutdown_req_o}, 0);
    bus_rd(0, rd); chk("R1 ctrl reset value", rd, 32'h0);
    bus_rd(4, rd); chk("R1 count reset value", rd, 32'hFFFF);
    bus_wr(4, 32'hABCD1234);
    bus_rd(5, rd); chk("R2 count upper bits dropped", rd, 32'h1234);

    // R6: basic expiry with reset action, P=8, N=3
    bus_wr(4, 3);
    bus_wr(0, 32'h81);
    bus_rd(0, rd); chk("R4 reload reads 0", rd, 32'h1);
    wait_pulse(1, 200, k, sd);
    chk("R6 expiry cycle N=3 P=8", k, 25);
    chk("R7 reset action selected", 32'(sd), 0);
    @(negedge clk_i);
    chk("R6 single cycle pulse", 32'(reset_req_o), 0);
    bus_rd(0, rd); chk("R8 fired set, run cleared R6", rd, 32'h2);
    bus_wr(0, 32'h02);
    bus_rd(0, rd); chk("R8 fired W1C", rd, 32'h0);

    // R7: shutdown action, P=4, N=2
    res_sel_i = 1;
    bus_wr(4, 2);
    bus_wr(0, 32'h85);
    wait_pulse(0, 200, k, sd);
    chk("R5 expiry cycle N=2 P=4", k, 9);
    chk("R7 shutdown action selected", 32'(sd), 1);
    bus_wr(0, 32'h04);
    bus_rd(0, rd); chk("R8 writing 0 keeps fired", rd, 32'h6);
    bus_wr(0, 32'h06);
    bus_rd(0, rd); chk("R8 fired cleared", rd, 32'h4);

    // R4 periodic reloads, R2 count write mid-run
    res_sel_i = 0;
    bus_wr(4, 5);
    bus_wr(0, 32'h81);
    for (int i = 0; i < 5; i++) begin
      repeat (29) @(negedge clk_i);
      bus_wr(0, 32'h81);
    end
    repeat (3) @(negedge clk_i);
    bus_wr(4, 1);
    wait_pulse(4, 300, k, sd);
    chk("R4/R2 expiry from last reload uses old count", k, 41);

    // R3 stop and resume
    bus_wr(0, 32'h02);
    bus_wr(4, 10);
    bus_wr(0, 32'h81);
    repeat (20) @(negedge clk_i);
    bus_wr(0, 32'h00);
    wait_pulse(0, 100, k, sd);
    chk("R3 stopped timer never fires", k, -1);
    bus_wr(0, 32'h01);
    wait_pulse(0, 300, k, sd);
    chk("R3 resume from held count", k, 65);

    // R9 strap
    bus_wr(0, 32'h02);
    disable_strap_i = 1;
    @(negedge clk_i);
    bus_wr(0, 32'h89);
    bus_rd(0, rd); chk("R9 strap blocks run, bit3 reads 1", rd, 32'h8);
    wait_pulse(0, 100, k, sd);
    chk("R9 no request under strap", k, -1);
    disable_strap_i = 0;
    bus_wr(0, 32'h81);
    repeat (5) @(negedge clk_i);
    disable_strap_i = 1;
    wait_pulse(0, 200, k, sd);
    chk("R9 strap during countdown", k, -1);
    bus_rd(0, rd); chk("R9 run cleared by strap", rd, 32'h8);
    disable_strap_i = 0;
    bus_wr(0, 32'h08);
    bus_rd(0, rd); chk("R9 bit3 write ignored", rd, 32'h0);

    // R6 zero count, R10 max count at P=1
    bus_wr(4, 0);
    bus_wr(0, 32'h81);
    wait_pulse(0, 10, k, sd);
    chk("R6 zero timeout", k, 1);
    bus_wr(0, 32'h02);
    res_sel_i = 3;
    bus_wr(4, 32'hFFFF);
    bus_wr(0, 32'h81);
    wait_pulse(0, 70000, k, sd);
    chk("R10 max timeout 65535 ticks", k, 65536);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule